// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Sequencer

This block sits between a clocked on-chip requester and an external asynchronous static RAM organised as 256K words of 16 bits. The requester presents a word address, write data, a two-bit lane mask and a direction flag, and raises a request. The block turns that request into a timed sequence of active-low strobes: chip select, write enable, output enable and one enable per byte lane. It returns read data together with a one-cycle acknowledge.

The memory's bidirectional data pins appear at the block's edge as three separate signals: an input, an output and a drive enable. All memory timing values are parameters in nanoseconds. Each one is turned into a cycle count by rounding up its division by the clock-period parameter, with a floor of one cycle. The block enforces these rules:

- Reads hold the strobes for the access time.
- Writes hold write enable low for the longer of the pulse-width and end-of-write setup requirements.
- The block waits for the memory to release the bus after a read before it drives the bus for a write.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip select, write enable, output enable and both lane enables are high, the data bus is not driven and ack is low.
- R2: A read (wr=0) drives chip select and output enable low and keeps write enable high. The lane enables are the inverse of the mask, where mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. These strobes hold for RD_CYC = max(ceil(T_RC/CLK_NS), ceil(T_AA/CLK_NS)) cycles, and the data is captured on the last of them. With the defaults this is 7 cycles, and ack rises RD_CYC clock edges after the edge that accepts the request.
- R3: In returned read data, every lane whose mask bit is 0 reads as zero, including the case where the mask is 00.
- R4: A write holds write enable low for WR_CYC = max(ceil(T_WP/CLK_NS), ceil(T_AW/CLK_NS), ceil(T_DW/CLK_NS)) cycles, which is 7 with the defaults. Chip select and the lane enables go low at least one cycle earlier. Only the lanes selected by the mask change in memory.
- R5: While write enable is low, the address, lane enables and driven data are stable. Write enable rises while chip select is still low, and chip select and the lane enables rise one cycle later.
- R6: The data bus is driven only while write enable is low, and output enable and write enable are never low together.
- R7: After output enable rises, the bus is not driven for at least TURN_CYC = ceil(T_HZ/CLK_NS) cycles, which is 3 with the defaults. A write accepted on the edge right after a read's ack therefore takes TURN_CYC-1 extra cycles.
- R8: Ack is high for exactly one cycle per access. An uncontended write acks WR_CYC+2 edges after acceptance.
- R9: A request is taken only in the idle state, and request inputs are latched there. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| bmask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| mem_addr | output | 18 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| dq_out | output | 16 | Data toward the memory |
| dq_in | input | 16 | Data from the memory |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
The hardest case to reach is a write accepted on the very edge after a read completes, while the memory is still releasing the bus. The bench reaches it by issuing the write in the same half-cycle in which it sees the read's ack. Its memory model measures the time from output enable rising to the first driven cycle. It also returns inverted data until the access time has elapsed, so a read captured early shows up as a data mismatch. Randomised back-to-back and gapped mixes of masked reads and writes then cover the turnaround under varied ordering.

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl #(
  parameter int CLK_NS = 8,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_WP   = 45,
  parameter int T_AW   = 50,
  parameter int T_DW   = 25,
  parameter int T_HZ   = 20,
  parameter int AW     = 18,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    bmask,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] dq_out,
  input  logic [DW-1:0] dq_in,
  output logic          dq_oe
);
  localparam int LW     = DW / 2;
  localparam int C_RC   = (T_RC + CLK_NS - 1) / CLK_NS;
  localparam int C_AA   = (T_AA + CLK_NS - 1) / CLK_NS;
  localparam int C_WP   = (T_WP + CLK_NS - 1) / CLK_NS;
  localparam int C_AW   = (T_AW + CLK_NS - 1) / CLK_NS;
  localparam int C_DW   = (T_DW + CLK_NS - 1) / CLK_NS;
  localparam int C_HZ   = (T_HZ + CLK_NS - 1) / CLK_NS;
  localparam int RD_R   = (C_RC > C_AA) ? C_RC : C_AA;
  localparam int RD_CYC = (RD_R > 1) ? RD_R : 1;
  localparam int WR_A   = (C_WP > C_AW) ? C_WP : C_AW;
  localparam int WR_B   = (WR_A > C_DW) ? WR_A : C_DW;
  localparam int WR_CYC = (WR_B > 1) ? WR_B : 1;
  localparam int TURN_CYC = (C_HZ > 1) ? C_HZ : 1;
  localparam int CMAX   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW     = $clog2(CMAX + 1) + 1;
  localparam int TW     = $clog2(TURN_CYC + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WR, S_WEND} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   turn;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q;
  logic [1:0]      mask_q;
  logic [DW-1:0]   lane_keep;

  assign mem_addr  = addr_q;
  assign dq_out    = wd_q;
  assign lane_keep = {{LW{mask_q[1]}}, {LW{mask_q[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      turn     <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
      mask_q   <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_ub_n <= 1'b1;
      mem_lb_n <= 1'b1;
      dq_oe    <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (turn != '0) turn <= turn - 1'b1;
      case (state)
        S_IDLE: if (req) begin
          addr_q   <= addr;
          wd_q     <= wdata;
          mask_q   <= bmask;
          mem_cs_n <= 1'b0;
          mem_lb_n <= ~bmask[0];
          mem_ub_n <= ~bmask[1];
          if (wr) begin
            state <= S_WSET;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(RD_CYC - 1);
            state    <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rdata    <= dq_in & lane_keep;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_ub_n <= 1'b1;
          mem_lb_n <= 1'b1;
          ack      <= 1'b1;
          turn     <= TW'(TURN_CYC);
          state    <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WSET: if (turn == '0) begin
          mem_we_n <= 1'b0;
          dq_oe    <= 1'b1;
          cnt      <= CW'(WR_CYC - 1);
          state    <= S_WR;
        end
        S_WR: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          dq_oe    <= 1'b0;
          state    <= S_WEND;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WEND: begin
          mem_cs_n <= 1'b1;
          mem_ub_n <= 1'b1;
          mem_lb_n <= 1'b1;
          ack      <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [7:0] chk_gap;
  always_ff @(posedge clk) begin
    if (!rst_n)           chk_gap <= 8'hff;
    else if (!mem_oe_n)   chk_gap <= '0;
    else if (chk_gap != 8'hff) chk_gap <= chk_gap + 1'b1;
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_oe_n)); // R6
  AST_STROBE_CS: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n || !mem_oe_n) |-> !mem_cs_n); // R2
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(dq_out) && $stable({mem_ub_n, mem_lb_n}))); // R5
  AST_WE_RISE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> !mem_cs_n); // R5
  AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R8
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(dq_oe) |-> (int'(chk_gap) >= TURN_CYC)); // R7
  AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n) ack |-> mem_cs_n); // R1
endmodule

// File: tb/sram_byte_ctrl_tb.sv
module sram_byte_ctrl_tb;
  localparam int CLK = 8;
  localparam int RDC = (55 + CLK - 1) / CLK;
  localparam int WRC = (50 + CLK - 1) / CLK;
  localparam int TRC = (20 + CLK - 1) / CLK;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0, rdata, dq_out, dq_in = '0;
  logic [1:0] bmask = '0;
  logic ack, cs_n, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [17:0] mem_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_byte_ctrl u_dut (.clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .bmask(bmask), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(cs_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_ub_n(ub_n), .mem_lb_n(lb_n),
    .dq_out(dq_out), .dq_in(dq_in), .dq_oe(dq_oe));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory and reference array
  logic [15:0] mem [int];
  logic [15:0] refm [int];
  function automatic logic [15:0] dflt(input int a);
    return 16'(a) ^ 16'h5a5a;
  endfunction
  function automatic logic [15:0] rd_mem(input int a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction
  function automatic logic [15:0] rd_ref(input int a);
    return refm.exists(a) ? refm[a] : dflt(a);
  endfunction

  int rd_age = 0, we_age = 0, cs_age = 0, oe_hi = 1000;
  logic [17:0] w_addr, rd_addr;
  logic [15:0] w_data;
  logic [1:0] w_be;
  bit prev_we_low = 0, prev_oe = 0, prev_ack = 0;

  always @(negedge clk) if (rst_n) begin
    bit rd_on;
    logic [15:0] v;
    rd_on = !cs_n && !oe_n && we_n && (!ub_n || !lb_n);
    if (rd_on && rd_age > 0 && mem_addr == rd_addr) rd_age++;
    else rd_age = rd_on ? 1 : 0;
    rd_addr = mem_addr;
    v = rd_mem(int'(mem_addr));
    if (!(rd_age * CLK >= 55)) v = ~v;
    dq_in <= {(rd_on && !ub_n) ? v[15:8] : 8'ha5, (rd_on && !lb_n) ? v[7:0] : 8'ha5};
    if (dq_oe && !oe_n) check(0, "R6 bus conflict", 1, 0);
    if (dq_oe && we_n) check(0, "R6 drive without write enable", 1, 0);
    if (dq_oe && !prev_oe) check((oe_hi - 1) * CLK >= 20, "R7 turnaround gap ns", (oe_hi - 1) * CLK, 20);
    prev_oe = dq_oe;
    oe_hi = !oe_n ? 0 : (oe_hi < 1000 ? oe_hi + 1 : oe_hi);
    cs_age = cs_n ? 0 : cs_age + 1;
    if (!cs_n && !we_n) begin
      if (we_age == 0) begin
        w_addr = mem_addr; w_data = dq_out; w_be = {!ub_n, !lb_n};
      end else if (mem_addr != w_addr || dq_out != w_data || w_be != {!ub_n, !lb_n})
        check(0, "R5 signal moved during write pulse", mem_addr, w_addr);
      we_age++;
      prev_we_low = 1;
    end else if (prev_we_low) begin
      check(we_age * CLK >= 45, "R4 write pulse ns", we_age * CLK, 45);
      check(!cs_n, "R5 chip select still low at write end", cs_n, 0);
      check((cs_age - 1) * CLK >= 50, "R4 select to end of write ns", (cs_age - 1) * CLK, 50);
      begin
        logic [15:0] o;
        o = rd_mem(int'(w_addr));
        if (w_be[0]) o[7:0] = w_data[7:0];
        if (w_be[1]) o[15:8] = w_data[15:8];
        mem[int'(w_addr)] = o;
      end
      we_age = 0;
      prev_we_low = 0;
    end
    if (ack && prev_ack) check(0, "R8 ack longer than one cycle", 1, 0);
    prev_ack = ack;
  end

  task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit scramble,
                       output logic [15:0] r, output int lat);
    lat = 0;
    req = 1; wr = w; addr = a; wdata = d; bmask = m;
    do begin
      @(negedge clk);
      lat++;
      if (scramble && lat == 3) begin
        addr = a ^ 18'h3; wdata = ~d; bmask = ~m; wr = ~w;
      end
    end while (!ack && lat < 100);
    r = rdata;
    req = 0;
    if (w) begin
      logic [15:0] o;
      o = rd_ref(int'(a));
      if (m[0]) o[7:0] = d[7:0];
      if (m[1]) o[15:8] = d[15:8];
      refm[int'(a)] = o;
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [17:0] a, input logic [1:0] m);
    logic [15:0] v;
    v = rd_ref(int'(a));
    return v & {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic idle_check(input string tag);
    check(cs_n && we_n && oe_n && ub_n && lb_n && !dq_oe && !ack, tag,
          {cs_n, we_n, oe_n, ub_n, lb_n, dq_oe, ack}, 7'b1111100);
  endtask

  initial begin
    logic [15:0] r;
    int lat;
    repeat (3) @(negedge clk);
    idle_check("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    idle_check("R1 idle after reset");

    do_op(1, 18'h10, 16'h1234, 2'b11, 0, r, lat);
    check(lat == WRC + 3, "R8 write latency", lat, WRC + 3);
    @(negedge clk); idle_check("R1 idle after write");
    @(negedge clk);
    do_op(0, 18'h10, 0, 2'b11, 0, r, lat);
    check(r == exp_rd(18'h10, 2'b11), "R2 read data", r, exp_rd(18'h10, 2'b11));
    check(lat == RDC + 1, "R2 read latency", lat, RDC + 1);
    do_op(1, 18'h10, 16'habcd, 2'b01, 0, r, lat);
    check(lat == WRC + 3 + TRC - 1, "R7 write right after read latency", lat, WRC + 2 + TRC);
    @(negedge clk);
    do_op(0, 18'h10, 0, 2'b11, 0, r, lat);
    check(r == 16'h12cd, "R4 lower lane write", r, 16'h12cd);
    do_op(1, 18'h10, 16'h5566, 2'b10, 0, r, lat);
    do_op(0, 18'h10, 0, 2'b11, 0, r, lat);
    check(r == 16'h55cd, "R4 upper lane write", r, 16'h55cd);
    do_op(0, 18'h10, 0, 2'b01, 0, r, lat);
    check(r == 16'h00cd, "R3 upper lane masked", r, 16'h00cd);
    do_op(0, 18'h10, 0, 2'b10, 0, r, lat);
    check(r == 16'h5500, "R3 lower lane masked", r, 16'h5500);
    do_op(0, 18'h10, 0, 2'b00, 0, r, lat);
    check(r == 16'h0000, "R3 empty mask", r, 0);
    do_op(0, 18'h20, 0, 2'b11, 1, r, lat);
    check(r == exp_rd(18'h20, 2'b11), "R9 read latched", r, exp_rd(18'h20, 2'b11));
    do_op(1, 18'h21, 16'hbeef, 2'b11, 1, r, lat);
    @(negedge clk);
    do_op(0, 18'h21, 0, 2'b11, 0, r, lat);
    check(r == 16'hbeef, "R9 write latched", r, 16'hbeef);
    check(rd_mem(18'h22) == dflt(18'h22), "R9 neighbour untouched", rd_mem(18'h22), dflt(18'h22));

    for (int i = 0; i < 200; i++) begin
      logic [17:0] a;
      logic [1:0] m;
      bit w;
      a = 18'h100 + 18'($urandom_range(0, 15));
      m = 2'($urandom_range(0, 3));
      w = $urandom_range(0, 1) == 1;
      do_op(w, a, 16'($urandom), m, 0, r, lat);
      if (!w) check(r == exp_rd(a, m), "R2 R3 random read", r, exp_rd(a, m));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    @(negedge clk);
    idle_check("R1 idle at end");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule